// File: doc/BRIEF.md
# Parallel-In Serial-Out Line Buffer

A processor or DMA engine writes one scan line of up to 320 sixteen-bit words into the block over a 16-bit bus. On a start command the block sends the stored line as a single-bit serial stream. The stream can begin with a programmable run of constant bits, all ones or all zeros. The words can go out in write order or in reverse order.

Each serial bit lasts a fixed number of system clock cycles: 1, 2, 4, 8 or 16. As an alternative, bits advance one at a time on rising edges of a request clock supplied by the receiving peripheral. A busy flag covers the whole transfer. A one-cycle interrupt marks its end. The line storage is cleared for refilling when the transfer starts.

Top module: `line_serializer`

## Requirements
- R1: After reset, `busy`, `irq`, `dma_req`, `sdata_out` and `sclk_out` are all 0. The line is empty, fixed length is 0 and all mode bits are 0.
- R2: A cycle with `sel`, `wr` and `cmd` all high is a command. `din[15:14]` selects the command: 00 writes the mode, 01 writes the fixed-run length from `din[13:0]`, 10 writes the DMA word count from `din[8:0]`, and 11 starts transmission. The mode fields are `din[0]` reverse order, `din[1]` request-clock source, `din[4:2]` divide code and `din[5]` fixed-run level. Commands other than start are ignored while busy.
- R3: A cycle with `sel` and `wr` high and `cmd` low stores `din` as the next line word. At most 320 words are kept, and further data writes are ignored.
- R4: `dma_req` is high while the block is idle and the DMA word count is nonzero. A cycle with `dma_ack` and `wr` high and `sel` low stores `din` as the next word and lowers the count by one.
- R5: The stream sends the fixed run of the programmed length at the programmed level first. Each word then follows with its most significant bit first. `sdata_out` is 0 when idle.
- R6: With reverse order clear, words go out in write order. With it set, the last-written word goes first, and the bit order within each word is unchanged.
- R7: In divided mode each bit lasts N = 2^code system cycles, and codes above 4 give N = 16. `sclk_out` is high during the first ceil(N/2) cycles of each bit period.
- R8: In request mode the stream advances one bit per rising edge of `req_clk`, as seen on `clk`. Without edges the current bit is held.
- R9: While `clk_en` is low the stream, the bit timing and the divider phase are frozen.
- R10: The cycle after a start command with a nonempty line, `busy` is 1 and the first bit is on `sdata_out`. `busy` falls right after the last bit period ends, and `irq` is 1 for exactly that one cycle. A start with an empty line is ignored.
- R11: Data writes on either path are ignored while busy. They neither alter the line being sent nor add to the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Processor bus select |
| wr | input | 1 | Write strobe, shared by both write paths |
| cmd | input | 1 | 1 = command write, 0 = data write |
| din | input | 16 | Write data bus |
| dma_ack | input | 1 | DMA acknowledge |
| req_clk | input | 1 | Peripheral request clock |
| clk_en | input | 1 | Transmission enable |
| dma_req | output | 1 | DMA request |
| sclk_out | output | 1 | Serial clock output |
| sdata_out | output | 1 | Serial data output |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The assertions assume that `req_clk` is already synchronous to `clk`, since it is only edge-detected on `clk`. They also assume that a command and a DMA write never arrive in the same cycle, which the `sel`-low condition on the DMA path enforces. The stimulus changes every input only on the falling clock edge and never asserts `sel` and `dma_ack` together. It holds `req_clk` high and low for a full cycle each. Mode, length and count are rewritten only while the block is idle, so the frozen-configuration assumption behind the timing checks always holds.

// File: rtl/line_serializer.sv
`timescale 1ns/1ps
module line_serializer #(
  parameter int WORDS = 320,
  parameter int WIDTH = 16,
  parameter int LENW  = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             wr,
  input  logic             cmd,
  input  logic [WIDTH-1:0] din,
  input  logic             dma_ack,
  input  logic             req_clk,
  input  logic             clk_en,
  output logic             dma_req,
  output logic             sclk_out,
  output logic             sdata_out,
  output logic             busy,
  output logic             irq
);
  localparam int AW = $clog2(WORDS);
  localparam int CW = $clog2(WORDS + 1);
  localparam int BW = $clog2(WIDTH);

  logic [WIDTH-1:0] mem [WORDS];
  logic [CW-1:0]    wptr, left, dma_left;
  logic [AW-1:0]    rptr;
  logic [BW-1:0]    bidx;
  logic [LENW-1:0]  fix_len, fix_left;
  logic             lifo, reqmode, pol, req_q, busy_r, irq_r;
  logic [2:0]       dcode;
  logic [3:0]       dcnt;

  wire [1:0] fsel   = din[WIDTH-1 -: 2];
  wire       cmd_wr = sel & wr & cmd;
  wire       dat_wr = wr & (sel ? ~cmd : dma_ack) & ~busy_r & (wptr < CW'(WORDS));
  wire [2:0] dc     = (dcode > 3'd4) ? 3'd4 : dcode;
  wire [4:0] nper   = 5'd1 << dc;
  wire [3:0] dtop   = 4'(nper - 5'd1);
  wire       tick   = busy_r & clk_en & (reqmode ? (req_clk & ~req_q) : (dcnt == dtop));
  wire       last   = tick & (fix_left == '0) & (bidx == '0) & (left == CW'(1));

  always_ff @(posedge clk)
    if (dat_wr) mem[AW'(wptr)] <= din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0; left <= '0; dma_left <= '0; rptr <= '0; bidx <= '0;
      fix_len <= '0; fix_left <= '0; lifo <= 1'b0; reqmode <= 1'b0; pol <= 1'b0;
      dcode <= '0; dcnt <= '0; req_q <= 1'b0; busy_r <= 1'b0; irq_r <= 1'b0;
    end else begin
      irq_r <= last;
      req_q <= req_clk;
      if (dat_wr) begin
        wptr <= wptr + CW'(1);
        if (!sel && dma_left != '0) dma_left <= dma_left - CW'(1);
      end
      if (cmd_wr && !busy_r) begin
        case (fsel)
          2'b00: begin
            lifo <= din[0]; reqmode <= din[1]; dcode <= din[4:2]; pol <= din[5];
          end
          2'b01: fix_len <= din[LENW-1:0];
          2'b10: dma_left <= din[CW-1:0];
          default: if (wptr != '0) begin
            busy_r   <= 1'b1;
            left     <= wptr;
            wptr     <= '0;
            rptr     <= lifo ? AW'(wptr - CW'(1)) : '0;
            bidx     <= BW'(WIDTH - 1);
            fix_left <= fix_len;
            dcnt     <= '0;
          end
        endcase
      end
      if (busy_r && clk_en && !reqmode) dcnt <= (dcnt == dtop) ? '0 : dcnt + 4'd1;
      if (tick) begin
        if (fix_left != '0)       fix_left <= fix_left - LENW'(1);
        else if (bidx != '0)      bidx <= bidx - BW'(1);
        else if (left == CW'(1))  busy_r <= 1'b0;
        else begin
          left <= left - CW'(1);
          bidx <= BW'(WIDTH - 1);
          rptr <= lifo ? rptr - AW'(1) : rptr + AW'(1);
        end
      end
    end
  end

  assign busy      = busy_r;
  assign irq       = irq_r;
  assign dma_req   = ~busy_r & (dma_left != '0);
  assign sdata_out = busy_r & ((fix_left != '0) ? pol : mem[rptr][bidx]);
  assign sclk_out  = busy_r & (reqmode ? req_clk : ({1'b0, dcnt} < ((nper + 5'd1) >> 1)));

  a_r10_irq_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    irq_r |-> !busy_r && $past(busy_r));
  a_r4_no_dma_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_r |-> !dma_req);
  a_r3_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    wptr <= CW'(WORDS));
  a_r5_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_r |-> !sdata_out);
  a_r11_no_fill_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_r |-> wptr == '0);
  a_r9_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    busy_r && !clk_en |=> $stable(fix_left) && $stable(bidx) && $stable(rptr) && $stable(dcnt));
endmodule

// File: tb/line_serializer_tb.sv
`timescale 1ns/1ps
module line_serializer_tb_top;
  logic clk = 0, rst_n = 0, sel = 0, wr = 0, cmd = 0, dma_ack = 0, req_clk = 0, clk_en = 1;
  logic [15:0] din = '0;
  logic dma_req, sclk_out, sdata_out, busy, irq;
  int tests = 0, fails = 0;
  bit done = 0;
  logic [15:0] m [320];
  int mn = 0, flen = 0;
  bit mpol = 0, mlifo = 0;

  always #4 clk = ~clk;

  line_serializer dut_i (.clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .cmd(cmd), .din(din),
    .dma_ack(dma_ack), .req_clk(req_clk), .clk_en(clk_en), .dma_req(dma_req),
    .sclk_out(sclk_out), .sdata_out(sdata_out), .busy(busy), .irq(irq));

  task automatic chk(input string r, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  function automatic bit exp_bit(input int k);
    int j, wi;
    logic [15:0] w;
    if (k < flen) return mpol;
    j = k - flen; wi = j / 16;
    w = mlifo ? m[mn-1-wi] : m[wi];
    return w[15 - (j % 16)];
  endfunction

  task automatic bus_wr(input bit c, input logic [15:0] d);
    @(negedge clk); sel = 1; wr = 1; cmd = c; din = d;
    @(negedge clk); sel = 0; wr = 0; cmd = 0;
  endtask

  task automatic push(input logic [15:0] w);
    bus_wr(0, w);
    if (mn < 320) begin m[mn] = w; mn++; end
  endtask

  task automatic set_mode(input bit lf, input bit rq, input int code, input bit p, input int len);
    bus_wr(1, {2'b00, 8'd0, p, 3'(code), rq, lf});
    bus_wr(1, {2'b01, 14'(len)});
    mlifo = lf; mpol = p; flen = len;
  endtask

  task automatic start();
    bus_wr(1, 16'hC000);
  endtask

  task automatic run_div(input int n, input string r);
    int total = flen + 16 * mn;
    for (int k = 0; k < total; k++)
      for (int c = 0; c < n; c++) begin
        chk({r, " bit"}, sdata_out, exp_bit(k));
        chk("R7 sclk", sclk_out, (c < (n + 1) / 2));
        chk("R10 busy", busy, 1);
        @(negedge clk);
      end
    chk("R10 busy end", busy, 0);
    chk("R10 irq", irq, 1);
    @(negedge clk);
    chk("R10 irq one cycle", irq, 0);
    mn = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL R10 watchdog actual=hang expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 busy", busy, 0); chk("R1 irq", irq, 0); chk("R1 dma_req", dma_req, 0);
    chk("R1 sdata", sdata_out, 0); chk("R1 sclk", sclk_out, 0);

    start();
    chk("R10 empty start ignored", busy, 0);

    // R2 R5 R6 R7: sweep divide code, order, level, run length
    for (int code = 0; code < 6; code++)
      for (int o = 0; o < 4; o++) begin
        set_mode(o[0], 0, code, o[1], o[1] ? 3 : (o[0] ? 1 : 0));
        for (int i = 0; i < 3; i++) push(16'(16'h9C31 * (i + 1) + code * 16'h1357 + o));
        start();
        run_div(code > 4 ? 16 : (1 << code), o[0] ? "R6 lifo" : "R5 fifo");
      end

    // R9: freeze right after start
    set_mode(0, 0, 1, 1, 2);
    push(16'hB00F);
    start();
    clk_en = 0;
    for (int i = 0; i < 6; i++) begin chk("R9 frozen bit", sdata_out, 1); @(negedge clk); end
    clk_en = 1;
    run_div(2, "R9 resumed");

    // R8: request clock
    set_mode(1, 1, 0, 0, 2);
    push(16'h1234); push(16'hFEC8);
    start();
    for (int k = 0; k < flen + 32; k++) begin
      chk("R8 bit", sdata_out, exp_bit(k));
      @(negedge clk);
      chk("R8 held", sdata_out, exp_bit(k));
      req_clk = 1;
      @(negedge clk);
      if (k == flen + 31) begin chk("R10 busy end", busy, 0); chk("R10 irq", irq, 1); end
      req_clk = 0;
      @(negedge clk);
    end
    chk("R10 irq one cycle", irq, 0);
    mn = 0;

    // R4: DMA fill
    set_mode(0, 0, 0, 0, 0);
    bus_wr(1, {2'b10, 14'd3});
    chk("R4 dma_req set", dma_req, 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); dma_ack = 1; wr = 1; din = 16'(16'h0F1E * (i + 3));
      m[mn] = din; mn++;
      @(negedge clk); dma_ack = 0; wr = 0;
    end
    chk("R4 dma_req clear", dma_req, 0);
    start();
    run_div(1, "R4 dma");

    // R11: writes while busy ignored
    set_mode(1, 0, 2, 0, 0);
    push(16'hA5A5); push(16'h3C3C);
    start();
    clk_en = 0;
    bus_wr(0, 16'hFFFF);
    @(negedge clk); dma_ack = 1; wr = 1; din = 16'h7777;
    @(negedge clk); dma_ack = 0; wr = 0;
    clk_en = 1;
    run_div(4, "R11 busy write");
    set_mode(0, 0, 0, 0, 0);
    push(16'h8001);
    start();
    run_div(1, "R11 next line");

    // R3: capacity
    for (int i = 0; i < 321; i++) push(16'(i * 16'h2F3B + 16'h1A2B));
    start();
    run_div(1, "R3 full line");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule